// File: doc/BRIEF.md
# Auto-Ranging Master Clock Prescaler

This block derives a 256 kHz sequencing enable from a master clock whose frequency is not configured but discovered. It counts master-clock cycles between successive rising edges of the 8 kHz transmit frame sync. It sorts that count into one of seven supported rates and, after two agreeing frames, adopts the matching divide ratio. The supported master clocks are 256 kHz, 512 kHz, 1.536 MHz, 1.544 MHz, 2.048 MHz, 2.56 MHz and 4.096 MHz.

The outputs are a single-cycle enable, `seqEn`, the active divide ratio, a flag marking the fractional 193-cycle rate, and a lock indicator. At 1.544 MHz the frame holds 193 cycles. The divider runs at ratio 6 and lengthens the first interval of every frame by one cycle, so each frame still yields exactly 32 enables. The divider restarts on every frame edge, so the enable train stays aligned to frame sync. Only the rising edge of frame sync matters, so long and short frame-sync formats behave the same.

Top module: `autoPrescaler`

## Requirements
- R1: While reset is held and right after it, `locked`, `seqEn`, `divRatio` and `fracMode` are all 0.
- R2: A period is the number of clock edges from one sampled rising edge of `frameSync` to the next. The first rising edge after reset only starts a measurement. The high time of `frameSync` has no effect. With a steady supported period, `locked` is 1 right after the third rising edge.
- R3: A measured count is classified as follows: 31..33 gives ratio 1, 63..65 gives 2, 191..192 gives 6, 193..194 gives 6 with `fracMode`=1, 255..257 gives 8, 319..321 gives 10, and 511..513 gives 16. Any other count is unsupported. `fracMode` is 1 only for the 193..194 class.
- R4: A ratio is adopted only when a count lands in the same class as the count of the frame before it. `divRatio`, `fracMode` and `locked`=1 appear in the cycle after the clock edge that samples the closing rising edge, and not earlier.
- R5: An unsupported count clears `locked` after its closing edge and leaves `divRatio` and `fracMode` unchanged. Regaining lock then takes two more agreeing frames.
- R6: A supported count whose class differs from the previous frame's class clears `locked` and keeps `divRatio`. The next frame of that same class restores lock with the new ratio.
- R7: While locked with `fracMode`=0 and ratio r, call the clock edge that samples a frame-sync rise edge 0. `seqEn` is high after edges r-1, 2r-1, 3r-1 and so on, for one cycle each.
- R8: While locked with `fracMode`=1, `seqEn` is high after edges 6, 12, 18 and so on, counted from the frame edge. The first interval of each frame is therefore 7 cycles and the rest are 6.
- R9: Every frame of a nominal period while locked holds exactly 32 `seqEn` pulses. The 32nd falls in the cycle that ends with the next frame edge.
- R10: `seqEn` stays 0 whenever `locked` is 0.
- R11: If no rising edge of `frameSync` is seen for 2^CNT_W-1 clock edges after the last frame edge, `locked` drops after that edge. With CNT_W=10, this is edge 1023.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rstN | input | 1 | Asynchronous reset, active low |
| frameSync | input | 1 | 8 kHz transmit frame sync, synchronous to clk |
| seqEn | output | 1 | Single-cycle enable at the 256 kHz sequencing rate |
| divRatio | output | DIV_W | Active divide ratio (0 until first lock) |
| fracMode | output | 1 | High when the 193-cycle fractional rate is active |
| locked | output | 1 | High while a confirmed ratio is in use |

## Verification
The delicate cycle is the one that samples a frame-sync rise while the divider is at terminal count. The restart and the 32nd enable of the ending frame coincide there. In the fractional case, the re-arming of the stretched interval also lands in that cycle. The bench drives each supported period from reset and predicts every `seqEn` position from the frame-edge distance. It then checks that each of two locked frames holds exactly 32 pulses, the last one right before the restart. A second overlap, ratio adoption on the same edge that restarts the divider, is judged by the first-cycle pulse position of the frame right after lock.

// File: rtl/prescalePkg.sv
package prescalePkg;

  localparam int NumClass = 7;
  localparam int ClsW     = $clog2(NumClass);

  typedef logic [ClsW-1:0] clsIdx_t;

  // control to datapath strobes
  typedef struct packed {
    logic    frameEdge;  // sampled rising edge of frame sync
    logic    loadRatio;  // adopt the class carried in newClass
    logic    runDiv;     // enables may be issued
    clsIdx_t newClass;
  } ctrlStrobe_t;

  // nominal master-clock cycles per 8 kHz frame, per class
  function automatic int nominalOf(int idx);
    case (idx)
      0:       return 32;
      1:       return 64;
      2:       return 192;
      3:       return 193;
      4:       return 256;
      5:       return 320;
      6:       return 512;
      default: return 0;
    endcase
  endfunction

  function automatic int ratioOf(int idx);
    case (idx)
      0:       return 1;
      1:       return 2;
      2:       return 6;
      3:       return 6;
      4:       return 8;
      5:       return 10;
      6:       return 16;
      default: return 0;
    endcase
  endfunction

  // only the 193-cycle class needs one stretched interval per frame
  function automatic logic stretchOf(int idx);
    return (idx == 3);
  endfunction

  // the 192 and 193 classes sit one apart, so each gives up the shared side
  function automatic int lowerOf(int idx, int tol);
    return (idx == 3) ? nominalOf(idx) : nominalOf(idx) - tol;
  endfunction

  function automatic int upperOf(int idx, int tol);
    return (idx == 2) ? nominalOf(idx) : nominalOf(idx) + tol;
  endfunction

endpackage

// File: rtl/autoPrescalerCtrl.sv
module autoPrescalerCtrl
  import prescalePkg::*;
#(
  parameter int CNT_W = 10,
  parameter int TOL   = 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             frameSync,
  input  logic [CNT_W-1:0] periodCount,
  output ctrlStrobe_t      strobe,
  output logic             locked
);

  localparam logic [CNT_W-1:0] CntMax = {CNT_W{1'b1}};

  logic    fsQ, armedQ, prevValidQ, lockedQ;
  clsIdx_t prevClsQ;

  logic                fsRise, measure, timeout;
  logic [NumClass-1:0] laneHit;
  clsIdx_t             clsNow;
  logic                clsValid, sameAsPrev;

  assign fsRise  = frameSync & ~fsQ;
  assign measure = fsRise & armedQ;
  assign timeout = armedQ & ~fsRise & (periodCount == CntMax);

  // one window comparator per supported rate
  for (genvar i = 0; i < NumClass; i++) begin : gLane
    localparam int Lo = lowerOf(i, TOL);
    localparam int Hi = upperOf(i, TOL);
    assign laneHit[i] = (periodCount >= CNT_W'(Lo)) && (periodCount <= CNT_W'(Hi));
  end

  // windows are disjoint, so at most one lane hits
  always_comb begin
    clsNow = '0;
    for (int i = 0; i < NumClass; i++) begin
      if (laneHit[i]) clsNow = clsIdx_t'(i);
    end
  end

  assign clsValid   = |laneHit;
  assign sameAsPrev = prevValidQ && (prevClsQ == clsNow);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      fsQ        <= 1'b0;
      armedQ     <= 1'b0;
      prevValidQ <= 1'b0;
      prevClsQ   <= '0;
      lockedQ    <= 1'b0;
    end else begin
      fsQ <= frameSync;
      if (fsRise) armedQ <= 1'b1;
      if (measure) begin
        if (!clsValid) begin
          prevValidQ <= 1'b0;
          lockedQ    <= 1'b0;
        end else if (sameAsPrev) begin
          lockedQ <= 1'b1;
        end else begin
          lockedQ    <= 1'b0;
          prevValidQ <= 1'b1;
          prevClsQ   <= clsNow;
        end
      end else if (timeout) begin
        lockedQ <= 1'b0;
      end
    end
  end

  always_comb begin
    strobe.frameEdge = fsRise;
    strobe.loadRatio = measure & clsValid & sameAsPrev;
    strobe.runDiv    = lockedQ;
    strobe.newClass  = clsNow;
  end

  assign locked = lockedQ;

endmodule

// File: rtl/autoPrescalerPath.sv
module autoPrescalerPath
  import prescalePkg::*;
#(
  parameter int CNT_W = 10,
  parameter int DIV_W = 5
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctrlStrobe_t      strobe,
  output logic [CNT_W-1:0] periodCount,
  output logic [DIV_W-1:0] divRatio,
  output logic             fracMode,
  output logic             seqEn
);

  localparam logic [CNT_W-1:0] CntMax = {CNT_W{1'b1}};

  logic [CNT_W-1:0] periodQ;
  logic [DIV_W-1:0] ratioQ, divCntQ;
  logic             fracQ, stretchQ;

  logic [DIV_W-1:0] loadRatioVal, lastVal;
  logic             loadFrac, nextFrac, terminal;

  always_comb begin
    loadRatioVal = DIV_W'(ratioOf(int'(strobe.newClass)));
    loadFrac     = stretchOf(int'(strobe.newClass));
    nextFrac     = strobe.loadRatio ? loadFrac : fracQ;
    lastVal      = ratioQ + DIV_W'(stretchQ) - DIV_W'(1);
    terminal     = (divCntQ == lastVal);
  end

  // cycles since the last frame edge, saturating
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                  periodQ <= '0;
    else if (strobe.frameEdge)  periodQ <= CNT_W'(1);
    else if (periodQ != CntMax) periodQ <= periodQ + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ratioQ <= '0;
      fracQ  <= 1'b0;
    end else if (strobe.loadRatio) begin
      ratioQ <= loadRatioVal;
      fracQ  <= loadFrac;
    end
  end

  // divider, realigned on every frame edge; first interval may be stretched
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      divCntQ  <= '0;
      stretchQ <= 1'b0;
    end else if (strobe.frameEdge) begin
      divCntQ  <= '0;
      stretchQ <= nextFrac;
    end else if (terminal) begin
      divCntQ  <= '0;
      stretchQ <= 1'b0;
    end else begin
      divCntQ  <= divCntQ + DIV_W'(1);
    end
  end

  assign periodCount = periodQ;
  assign divRatio    = ratioQ;
  assign fracMode    = fracQ;
  assign seqEn       = strobe.runDiv & terminal;

endmodule

// File: rtl/autoPrescaler.sv
module autoPrescaler
  import prescalePkg::*;
#(
  parameter int CNT_W = 10,
  parameter int DIV_W = 5,
  parameter int TOL   = 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             frameSync,
  output logic             seqEn,
  output logic [DIV_W-1:0] divRatio,
  output logic             fracMode,
  output logic             locked
);

  ctrlStrobe_t      strobe;
  logic [CNT_W-1:0] periodCount;

  autoPrescalerCtrl #(.CNT_W(CNT_W), .TOL(TOL)) u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .frameSync   (frameSync),
    .periodCount (periodCount),
    .strobe      (strobe),
    .locked      (locked)
  );

  autoPrescalerPath #(.CNT_W(CNT_W), .DIV_W(DIV_W)) u_path (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .periodCount (periodCount),
    .divRatio    (divRatio),
    .fracMode    (fracMode),
    .seqEn       (seqEn)
  );

endmodule

// File: rtl/autoPrescalerChk.sv
module autoPrescalerChk #(
  parameter int DIV_W = 5
) (
  input logic             clk,
  input logic             rstN,
  input logic             frameSync,
  input logic             seqEn,
  input logic [DIV_W-1:0] divRatio,
  input logic             fracMode,
  input logic             locked
);

  logic fsSeenQ;
  logic riseNow;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) fsSeenQ <= 1'b0;
    else       fsSeenQ <= frameSync;
  end

  assign riseNow = frameSync & ~fsSeenQ;

  a_r10_quiet_unlocked: assert property (@(posedge clk) disable iff (!rstN)
    !locked |-> !seqEn);

  a_r4_lock_known_ratio: assert property (@(posedge clk) disable iff (!rstN)
    locked |-> (divRatio != '0));

  a_r4_lock_at_edge: assert property (@(posedge clk) disable iff (!rstN)
    $rose(locked) |-> $past(riseNow));

  a_r5_ratio_holds: assert property (@(posedge clk) disable iff (!rstN)
    !$past(riseNow) |-> ($stable(divRatio) && $stable(fracMode)));

  a_r7_spacing: assert property (@(posedge clk) disable iff (!rstN)
    (seqEn && locked && (divRatio >= DIV_W'(2))) |=> !seqEn);

  a_r8_frac_six: assert property (@(posedge clk) disable iff (!rstN)
    fracMode |-> (divRatio == DIV_W'(6)));

  a_r3_legal_ratio: assert property (@(posedge clk) disable iff (!rstN)
    divRatio inside {DIV_W'(0), DIV_W'(1), DIV_W'(2), DIV_W'(6),
                     DIV_W'(8), DIV_W'(10), DIV_W'(16)});

endmodule

bind autoPrescaler autoPrescalerChk #(.DIV_W(DIV_W)) u_chk (.*);

// File: tb/autoPrescaler_tb.sv
`timescale 1ns/1ps
module autoPrescaler_tb;

  logic       clk;
  logic       rstN;
  logic       frameSync;
  logic       seqEn;
  logic [4:0] divRatio;
  logic       fracMode;
  logic       locked;

  int checks   = 0;
  int failures = 0;
  int sinceEdge;
  logic fsLast;
  bit done = 0;

  autoPrescaler u_dut (
    .clk       (clk),
    .rstN      (rstN),
    .frameSync (frameSync),
    .seqEn     (seqEn),
    .divRatio  (divRatio),
    .fracMode  (fracMode),
    .locked    (locked)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic check(string req, int act, int exp, string what);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // bench model of the class table
  function automatic bit modelClass(int p, output int r, output int s);
    int nom[7] = '{32, 64, 192, 193, 256, 320, 512};
    int rat[7] = '{1, 2, 6, 6, 8, 10, 16};
    r = 0; s = 0;
    for (int k = 0; k < 7; k++) begin
      int lo, hi;
      lo = (k == 3) ? nom[k] : nom[k] - 1;
      hi = (k == 2) ? nom[k] : nom[k] + 1;
      if (p >= lo && p <= hi) begin
        r = rat[k];
        s = (k == 3);
        return 1'b1;
      end
    end
    return 1'b0;
  endfunction

  // called at a negedge; returns at the next negedge
  task automatic tick(input logic fsNext);
    frameSync = fsNext;
    @(posedge clk);
    if (fsNext && !fsLast) sinceEdge = 0;
    else                   sinceEdge++;
    fsLast = fsNext;
    @(negedge clk);
  endtask

  task automatic doReset();
    rstN      = 1'b0;
    frameSync = 1'b0;
    fsLast    = 1'b0;
    sinceEdge = 100000;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
  endtask

  task automatic idle(int n, bit expectQuiet);
    for (int k = 0; k < n; k++) begin
      tick(1'b0);
      if (expectQuiet) check("R10", int'(seqEn), 0, "seqEn while unlocked");
    end
  endtask

  // mode 0: no checks, 1: expect unlocked and quiet, 2: expect locked enable train
  task automatic runFrame(int period, int width, int mode, int r, int s,
                          output int pulses);
    pulses = 0;
    for (int d = 0; d < period; d++) begin
      tick(d < width);
      if (seqEn) pulses++;
      if (mode == 1) begin
        check("R10", int'(seqEn), 0, "seqEn while unlocked");
      end else if (mode == 2) begin
        int v;
        v = d + 1 - s;
        if (s != 0) check("R8", int'(seqEn), int'(v >= r && v % r == 0), "fractional enable position");
        else        check("R7", int'(seqEn), int'(v >= r && v % r == 0), "enable position");
        if (d == 0) begin
          check("R2", int'(locked), 1, "locked after third edge");
          check("R3", int'(divRatio), r, "adopted ratio");
          check("R3", int'(fracMode), s, "fractional flag");
        end
      end
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int pulses;
    int perArr[7] = '{32, 64, 192, 193, 256, 320, 512};
    int bnd[26]   = '{30, 31, 33, 34, 62, 63, 65, 66, 190, 191, 192, 193, 194, 195,
                      254, 255, 257, 258, 318, 319, 321, 322, 510, 511, 513, 514};

    // R1: reset state
    rstN = 1'b0;
    frameSync = 1'b0;
    repeat (2) @(negedge clk);
    check("R1", int'(locked), 0, "locked in reset");
    check("R1", int'(seqEn), 0, "seqEn in reset");
    doReset();
    check("R1", int'(locked), 0, "locked after reset");
    check("R1", int'(divRatio), 0, "divRatio after reset");
    check("R1", int'(fracMode), 0, "fracMode after reset");
    check("R1", int'(seqEn), 0, "seqEn after reset");

    // sweep every supported rate, short and long frame-sync pulses
    for (int m = 0; m < 7; m++) begin
      int p, w, r, s;
      bit ok;
      p  = perArr[m];
      w  = (m % 2 == 0) ? 1 : p / 2;
      ok = modelClass(p, r, s);
      doReset();
      runFrame(p, w, 1, r, s, pulses);
      runFrame(p, w, 1, r, s, pulses);
      check("R4", int'(locked), 0, "no lock after a single measured frame");
      runFrame(p, w, 2, r, s, pulses);
      check("R9", pulses, 32, "enables in first locked frame");
      runFrame(p, w, 2, r, s, pulses);
      check("R9", pulses, 32, "enables in second locked frame");
    end

    // R3: class window boundaries
    for (int b = 0; b < 26; b++) begin
      int p, r, s;
      bit ok;
      p  = bnd[b];
      ok = modelClass(p, r, s);
      doReset();
      runFrame(p, 1, 0, 1, 0, pulses);
      runFrame(p, 1, 0, 1, 0, pulses);
      tick(1'b1);
      check("R3", int'(locked), int'(ok), "lock at window boundary");
      check("R3", int'(divRatio), ok ? r : 0, "ratio at window boundary");
      check("R3", int'(fracMode), s, "fractional flag at window boundary");
    end

    // R5: unsupported count
    doReset();
    runFrame(256, 1, 0, 8, 0, pulses);
    runFrame(256, 1, 0, 8, 0, pulses);
    runFrame(256, 1, 0, 8, 0, pulses);
    runFrame(100, 1, 0, 8, 0, pulses);
    tick(1'b1);
    check("R5", int'(locked), 0, "unsupported count unlocks");
    check("R5", int'(divRatio), 8, "ratio kept after unsupported count");
    check("R5", int'(fracMode), 0, "fractional flag kept");
    idle(255, 1'b1);
    tick(1'b1);
    check("R5", int'(locked), 0, "one good frame is not enough");
    idle(255, 1'b1);
    tick(1'b1);
    check("R5", int'(locked), 1, "relock after two good frames");
    check("R4", int'(divRatio), 8, "ratio after relock");

    // R6: change of supported rate
    doReset();
    runFrame(64, 1, 0, 2, 0, pulses);
    runFrame(64, 1, 0, 2, 0, pulses);
    runFrame(64, 1, 0, 2, 0, pulses);
    check("R6", int'(locked), 1, "locked at ratio 2");
    tick(1'b1);
    idle(319, 1'b0);
    tick(1'b1);
    check("R6", int'(locked), 0, "rate change unlocks");
    check("R6", int'(divRatio), 2, "old ratio kept");
    idle(319, 1'b1);
    tick(1'b1);
    check("R6", int'(locked), 1, "relock at new rate");
    check("R6", int'(divRatio), 10, "new ratio adopted");

    // R11: frame sync stops
    doReset();
    runFrame(32, 1, 0, 1, 0, pulses);
    runFrame(32, 1, 0, 1, 0, pulses);
    runFrame(32, 1, 0, 1, 0, pulses);
    tick(1'b1);
    idle(1021, 1'b0);
    tick(1'b0);
    check("R11", int'(locked), 1, "still locked at edge 1022");
    tick(1'b0);
    check("R11", int'(locked), 0, "lock lost at edge 1023");
    check("R11", int'(divRatio), 1, "ratio kept after timeout");
    tick(1'b0);
    check("R10", int'(seqEn), 0, "no enable after timeout");

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule